// File: doc/BRIEF.md
# Vectored Nested Priority Interrupt Controller

The controller gathers up to 32 interrupt lines and presents one active-low request, `irq_n`, to a processor. A simple register bus configures every line. It sets a trigger type, a priority level and a software-chosen vector word, and it enables, disables and clears lines. Edge-triggered lines latch a pending flag. Level-triggered lines are pending for as long as their input sits at the active level.

The processor services a request by reading the vector register, and that read is the acknowledge. It returns the vector word of the winning line and pushes the line's priority and number onto a hardware nesting stack of up to eight entries. While an interrupt is in service, only a strictly higher priority may assert `irq_n` again. Each write to the end-of-interrupt register pops one stack entry. If nothing is eligible when the vector register is read, a programmable spurious vector is returned, the stack is left alone and the status register reads zero.

The nesting stack is a three-state machine over its fill level:

- `ST_IDLE` is the empty state. It moves to `ST_NEST` on an acknowledge.
- `ST_NEST` is partly filled. It stays in `ST_NEST` on an acknowledge or an end-of-interrupt. It moves to `ST_IDLE` when the last entry is popped, and to `ST_FULL` when an acknowledge fills the final slot.
- `ST_FULL` moves back to `ST_NEST` on an end-of-interrupt. It ignores acknowledges.

Top module: `vnic_ctrl`

Register map (word addresses, default parameters):

| Address | Meaning |
|---|---|
| 0..31 | Mode register of line n |
| 32..63 | Vector word of line n |
| 64 | Vector: a read acknowledges |
| 65 | Status |
| 66 | Spurious vector |
| 67 | Enable set, write one to set; a read returns the enable mask |
| 68 | Enable clear, write one to clear |
| 69 | Pending clear, write one to clear |
| 70 | End of interrupt |

## Requirements
- R1: After reset `irq_n` is 1, the status register reads 0, the enable mask reads 0, the nesting stack is empty and the spurious vector is 0.
- R2: Mode register layout is as follows. Bits [2:0] hold the priority, where 7 is the highest. Bits [5:4] hold the trigger type: 0 is high level, 1 is rising edge, 2 is low level and 3 is falling edge. A legal write reads back the same value.
- R3: A mode write with trigger 2 or 3 to a line that is neither line 0 nor an external line (default external lines: 20..23) is ignored as a whole, and the register keeps its old value.
- R4: Writing a one to a bit of the enable-set address enables that line. Writing a one to a bit of the enable-clear address disables that line, so writing all ones disables every line. Only enabled lines can request.
- R5: An edge-triggered line latches pending on its active edge. Writing a one to its bit at the pending-clear address drops the latch.
- R6: A level-triggered line is pending exactly while its input is at the active level. It is never latched.
- R7: A read of the vector register returns the vector word of the enabled pending line with the highest priority, with the lowest line number winning ties. That line becomes current, and the status register then reads its number.
- R8: `irq_n` is 0 exactly when some enabled pending line has a priority strictly greater than the priority on top of the nesting stack, or when such a line exists and the stack is empty. An equal priority does not preempt.
- R9: A vector read with no eligible line returns the spurious-vector register, does not push, and makes the status read 0.
- R10: Each end-of-interrupt write pops the most recent entry, whatever the written data. A write with the stack empty has no effect, and eight writes always reach the empty state.
- R11: Acknowledging an edge-triggered line clears its pending latch.
- R12: The nesting stack never overflows; no acknowledge occurs with eight entries held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_i | input | 32 | Interrupt source lines |
| bus_addr | input | 7 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe; a read at address 64 acknowledges |
| bus_rdata | output | 32 | Read data, valid in the cycle of the read strobe |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The hardest state to reach from the ports is a completely full nesting stack, which needs eight acknowledges at eight rising priorities while every lower line stays pending. The bench builds it by raising level-triggered lines one at a time with priorities 0 through 7 and acknowledging each. It then unwinds the stack with end-of-interrupt writes, checking the status at every step, and issues one extra write on the empty stack. Random mixes of enabled level lines with random priorities exercise the tie-break against a bench model.

// File: rtl/vnic_pkg.sv
package vnic_pkg;

    // Trigger encodings held in the mode register
    typedef enum logic [1:0] {
        TRIG_LVL_HI = 2'd0,
        TRIG_RISE   = 2'd1,
        TRIG_LVL_LO = 2'd2,
        TRIG_FALL   = 2'd3
    } trig_e;

    // Nesting stack fill states
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_NEST = 2'd1,
        ST_FULL = 2'd2
    } nest_state_e;

    // Control register offsets above the per-line banks
    localparam int OFS_VECTOR   = 0;
    localparam int OFS_STATUS   = 1;
    localparam int OFS_SPUR     = 2;
    localparam int OFS_EN_SET   = 3;
    localparam int OFS_EN_CLR   = 4;
    localparam int OFS_PEND_CLR = 5;
    localparam int OFS_EOI      = 6;

    // Trigger field position inside the mode word
    localparam int TRIG_LSB = 4;

endpackage

// File: rtl/vnic_src_cell.sv
module vnic_src_cell
    import vnic_pkg::*;
#(
    parameter int PRIO_W    = 3,
    parameter int DATA_W    = 32,
    parameter bit ALLOW_LOW = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              src_i,
    input  logic              mode_we,
    input  logic [1:0]        mode_trig,
    input  logic [PRIO_W-1:0] mode_pri,
    input  logic              vec_we,
    input  logic [DATA_W-1:0] vec_wdata,
    input  logic              en_set,
    input  logic              en_clr,
    input  logic              pend_clr,
    input  logic              ack,
    output logic              req,
    output logic [PRIO_W-1:0] pri,
    output logic [1:0]        trig,
    output logic [DATA_W-1:0] vec,
    output logic              en
);

    logic src_q, src_p, latch_q;
    logic legal, inv, edge_mode, lvl, lvl_p, edge_evt, pending;

    assign legal     = ALLOW_LOW || !mode_trig[1];
    assign inv       = trig[1];
    assign edge_mode = trig[0];
    assign lvl       = src_q ^ inv;
    assign lvl_p     = src_p ^ inv;
    assign edge_evt  = edge_mode & lvl & ~lvl_p;
    assign pending   = edge_mode ? latch_q : lvl;
    assign req       = en & pending;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_q   <= 1'b0;
            src_p   <= 1'b0;
            trig    <= TRIG_LVL_HI;
            pri     <= '0;
            vec     <= '0;
            en      <= 1'b0;
            latch_q <= 1'b0;
        end else begin
            src_q <= src_i;
            src_p <= src_q;
            if (mode_we && legal) begin
                trig <= mode_trig;
                pri  <= mode_pri;
            end
            if (vec_we) vec <= vec_wdata;
            if (en_clr)      en <= 1'b0;
            else if (en_set) en <= 1'b1;
            if (!edge_mode || ack || pend_clr) latch_q <= 1'b0;
            else if (edge_evt)                 latch_q <= 1'b1;
        end
    end

endmodule

// File: rtl/vnic_arbiter.sv
module vnic_arbiter #(
    parameter int NUM_SRC = 32,
    parameter int PRIO_W  = 3,
    parameter int IDX_W   = 5
) (
    input  logic [NUM_SRC-1:0]        req,
    input  logic [NUM_SRC*PRIO_W-1:0] pri_flat,
    input  logic                      stk_empty,
    input  logic                      stk_full,
    input  logic [PRIO_W-1:0]         top_pri,
    output logic                      found,
    output logic [IDX_W-1:0]          win_idx
);

    logic [PRIO_W-1:0] best;

    always_comb begin
        found   = 1'b0;
        win_idx = '0;
        best    = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (req[i] && !stk_full &&
                (stk_empty || pri_flat[i*PRIO_W +: PRIO_W] > top_pri) &&
                (!found || pri_flat[i*PRIO_W +: PRIO_W] > best)) begin
                found   = 1'b1;
                best    = pri_flat[i*PRIO_W +: PRIO_W];
                win_idx = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/vnic_nest_stack.sv
module vnic_nest_stack
    import vnic_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int PRIO_W = 3,
    parameter int IDX_W  = 5,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [PRIO_W-1:0] push_pri,
    input  logic [IDX_W-1:0]  push_idx,
    input  logic              pop,
    output logic              empty,
    output logic              full,
    output logic [PRIO_W-1:0] top_pri,
    output logic [IDX_W-1:0]  top_idx,
    output logic [CNT_W-1:0]  count
);

    nest_state_e state_q, state_d;
    logic [PRIO_W-1:0] pri_stk [DEPTH];
    logic [IDX_W-1:0]  idx_stk [DEPTH];
    logic [PTR_W-1:0]  top_ptr;
    logic do_push, do_pop;

    assign do_pop  = pop  && (state_q != ST_IDLE);
    assign do_push = push && !pop && (state_q != ST_FULL);
    assign top_ptr = PTR_W'(count - CNT_W'(1));
    assign top_pri = pri_stk[top_ptr];
    assign top_idx = idx_stk[top_ptr];

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (do_push) state_d = (DEPTH == 1) ? ST_FULL : ST_NEST;
            ST_NEST: begin
                if (do_pop)
                    state_d = (count == CNT_W'(1)) ? ST_IDLE : ST_NEST;
                else if (do_push)
                    state_d = (count == CNT_W'(DEPTH - 1)) ? ST_FULL : ST_NEST;
            end
            ST_FULL: if (do_pop) state_d = (DEPTH == 1) ? ST_IDLE : ST_NEST;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register, fill count and entries
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            count   <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                pri_stk[i] <= '0;
                idx_stk[i] <= '0;
            end
        end else begin
            state_q <= state_d;
            if (do_pop) begin
                count <= count - CNT_W'(1);
            end else if (do_push) begin
                count                      <= count + CNT_W'(1);
                pri_stk[PTR_W'(count)]     <= push_pri;
                idx_stk[PTR_W'(count)]     <= push_idx;
            end
        end
    end

    // Outputs per state
    always_comb begin
        unique case (state_q)
            ST_IDLE: begin empty = 1'b1; full = 1'b0; end
            ST_NEST: begin empty = 1'b0; full = 1'b0; end
            ST_FULL: begin empty = 1'b0; full = 1'b1; end
            default: begin empty = 1'b1; full = 1'b0; end
        endcase
    end

endmodule

// File: rtl/vnic_ctrl.sv
module vnic_ctrl
    import vnic_pkg::*;
#(
    parameter int NUM_SRC = 32,
    parameter int PRIO_W  = 3,
    parameter int DEPTH   = 8,
    parameter int ADDR_W  = 7,
    parameter int DATA_W  = 32,
    parameter logic [NUM_SRC-1:0] EXT_MASK = NUM_SRC'(32'h00F0_0000)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    input  logic               bus_we,
    input  logic               bus_re,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic               irq_n
);

    localparam int IDX_W    = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
    localparam int CNT_W    = $clog2(DEPTH + 1);
    localparam int VEC_BASE = NUM_SRC;
    localparam int CTL_BASE = 2 * NUM_SRC;

    logic [NUM_SRC-1:0]        req, en;
    logic [NUM_SRC*PRIO_W-1:0] pri_flat;
    logic [PRIO_W-1:0]         pri_arr  [NUM_SRC];
    logic [1:0]                trig_arr [NUM_SRC];
    logic [DATA_W-1:0]         vec_arr  [NUM_SRC];

    logic              found, stk_empty, stk_full, spur_q;
    logic [IDX_W-1:0]  win_idx, top_idx;
    logic [PRIO_W-1:0] top_pri;
    logic [CNT_W-1:0]  stk_count;
    logic [DATA_W-1:0] spur_vec_q, status_val;
    logic              vec_rd, eoi_we, ack, spur_rd;
    logic              en_set_we, en_clr_we, pend_clr_we;
    logic [ADDR_W-1:0] rel;

    assign vec_rd      = bus_re && (bus_addr == ADDR_W'(CTL_BASE + OFS_VECTOR));
    assign eoi_we      = bus_we && (bus_addr == ADDR_W'(CTL_BASE + OFS_EOI));
    assign en_set_we   = bus_we && (bus_addr == ADDR_W'(CTL_BASE + OFS_EN_SET));
    assign en_clr_we   = bus_we && (bus_addr == ADDR_W'(CTL_BASE + OFS_EN_CLR));
    assign pend_clr_we = bus_we && (bus_addr == ADDR_W'(CTL_BASE + OFS_PEND_CLR));
    assign ack         = vec_rd && found && !eoi_we;
    assign spur_rd     = vec_rd && !found && !eoi_we;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        vnic_src_cell #(
            .PRIO_W    (PRIO_W),
            .DATA_W    (DATA_W),
            .ALLOW_LOW (EXT_MASK[g] || (g == 0))
        ) u_cell (
            .clk       (clk),
            .rst_n     (rst_n),
            .src_i     (src_i[g]),
            .mode_we   (bus_we && (bus_addr == ADDR_W'(g))),
            .mode_trig (bus_wdata[TRIG_LSB +: 2]),
            .mode_pri  (bus_wdata[PRIO_W-1:0]),
            .vec_we    (bus_we && (bus_addr == ADDR_W'(VEC_BASE + g))),
            .vec_wdata (bus_wdata),
            .en_set    (en_set_we && bus_wdata[g]),
            .en_clr    (en_clr_we && bus_wdata[g]),
            .pend_clr  (pend_clr_we && bus_wdata[g]),
            .ack       (ack && (win_idx == IDX_W'(g))),
            .req       (req[g]),
            .pri       (pri_arr[g]),
            .trig      (trig_arr[g]),
            .vec       (vec_arr[g]),
            .en        (en[g])
        );
        assign pri_flat[g*PRIO_W +: PRIO_W] = pri_arr[g];
    end

    vnic_arbiter #(
        .NUM_SRC (NUM_SRC),
        .PRIO_W  (PRIO_W),
        .IDX_W   (IDX_W)
    ) u_arb (
        .req       (req),
        .pri_flat  (pri_flat),
        .stk_empty (stk_empty),
        .stk_full  (stk_full),
        .top_pri   (top_pri),
        .found     (found),
        .win_idx   (win_idx)
    );

    vnic_nest_stack #(
        .DEPTH  (DEPTH),
        .PRIO_W (PRIO_W),
        .IDX_W  (IDX_W)
    ) u_stack (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (ack),
        .push_pri (pri_arr[win_idx]),
        .push_idx (win_idx),
        .pop      (eoi_we),
        .empty    (stk_empty),
        .full     (stk_full),
        .top_pri  (top_pri),
        .top_idx  (top_idx),
        .count    (stk_count)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            spur_vec_q <= '0;
            spur_q     <= 1'b0;
        end else begin
            if (bus_we && (bus_addr == ADDR_W'(CTL_BASE + OFS_SPUR)))
                spur_vec_q <= bus_wdata;
            if (ack || eoi_we) spur_q <= 1'b0;
            else if (spur_rd)  spur_q <= 1'b1;
        end
    end

    assign status_val = (stk_empty || spur_q) ? '0 : DATA_W'(top_idx);
    assign irq_n      = ~found;

    always_comb begin
        bus_rdata = '0;
        rel       = bus_addr - ADDR_W'(VEC_BASE);
        if (bus_addr < ADDR_W'(NUM_SRC)) begin
            bus_rdata[PRIO_W-1:0]     = pri_arr[bus_addr[IDX_W-1:0]];
            bus_rdata[TRIG_LSB +: 2]  = trig_arr[bus_addr[IDX_W-1:0]];
        end else if (bus_addr < ADDR_W'(CTL_BASE)) begin
            bus_rdata = vec_arr[rel[IDX_W-1:0]];
        end else if (bus_addr == ADDR_W'(CTL_BASE + OFS_VECTOR)) begin
            bus_rdata = found ? vec_arr[win_idx] : spur_vec_q;
        end else if (bus_addr == ADDR_W'(CTL_BASE + OFS_STATUS)) begin
            bus_rdata = status_val;
        end else if (bus_addr == ADDR_W'(CTL_BASE + OFS_SPUR)) begin
            bus_rdata = spur_vec_q;
        end else if (bus_addr == ADDR_W'(CTL_BASE + OFS_EN_SET)) begin
            bus_rdata = DATA_W'(en);
        end
    end

endmodule

// File: rtl/vnic_ctrl_chk.sv
module vnic_ctrl_chk #(
    parameter int DEPTH  = 8,
    parameter int CNT_W  = 4,
    parameter int IDX_W  = 5,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              irq_n,
    input logic              vec_rd,
    input logic              eoi_we,
    input logic              ack,
    input logic [IDX_W-1:0]  win_idx,
    input logic [CNT_W-1:0]  depth,
    input logic [DATA_W-1:0] status_val
);

    a_r1_reset_empty: assert property (@(posedge clk)
        !rst_n |=> (depth == '0));

    a_r12_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> (depth < CNT_W'(DEPTH)));

    a_r10_eoi_pops: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_we && depth != '0) |=> (depth == $past(depth) - CNT_W'(1)));

    a_r8_request_acked: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_rd && !irq_n && !eoi_we) |=> (depth == $past(depth) + CNT_W'(1)));

    a_r9_spur_no_push: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_rd && irq_n && !eoi_we) |=> $stable(depth));

    a_r7_status_current: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> (status_val == DATA_W'($past(win_idx))));

    a_r9_idle_status: assert property (@(posedge clk) disable iff (!rst_n)
        (depth == '0) |-> (status_val == '0));

endmodule

bind vnic_ctrl vnic_ctrl_chk #(
    .DEPTH  (DEPTH),
    .CNT_W  (CNT_W),
    .IDX_W  (IDX_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .irq_n      (irq_n),
    .vec_rd     (vec_rd),
    .eoi_we     (eoi_we),
    .ack        (ack),
    .win_idx    (win_idx),
    .depth      (stk_count),
    .status_val (status_val)
);

// File: tb/vnic_ctrl_bench.sv
module vnic_ctrl_bench;

    localparam int CLK_PERIOD = 10;
    localparam int A_VEC  = 64, A_STAT = 65, A_SPUR = 66;
    localparam int A_ENS  = 67, A_ENC  = 68, A_PCLR = 69, A_EOI = 70;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src = '0;
    logic [6:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic        we = 1'b0, re = 1'b0;
    logic [31:0] rdata;
    logic        irq_n;

    int tests = 0;
    int fails = 0;
    logic [31:0] spur_val;
    logic [2:0]  m_pri [32];

    always #(CLK_PERIOD/2) clk = ~clk;

    vnic_ctrl u_vnic_ctrl (
        .clk (clk), .rst_n (rst_n), .src_i (src), .bus_addr (addr),
        .bus_wdata (wdata), .bus_we (we), .bus_re (re),
        .bus_rdata (rdata), .irq_n (irq_n)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        addr = 7'(a); wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        @(negedge clk);
        addr = 7'(a); re = 1'b1;
        #1 d = rdata;
        @(negedge clk);
        re = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cfg(input int i, input logic [1:0] trig, input logic [2:0] pri, input logic [31:0] vec);
        wr(i, {26'd0, trig, 1'b0, pri});
        wr(32 + i, vec);
        m_pri[i] = pri;
    endtask

    function automatic int winner(input logic [31:0] act);
        int w = -1;
        for (int i = 0; i < 32; i++)
            if (act[i] && (w < 0 || m_pri[i] > m_pri[w])) w = i;
        return w;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got %h expected %h", 0, 1);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [31:0] d;
        for (int i = 0; i < 32; i++) m_pri[i] = '0;
        void'($urandom(32'd1234));
        idle(4);
        rst_n = 1'b1;
        idle(2);

        // R1 reset state
        check("R1 irq_n", 32'(irq_n), 32'd1);
        rd(A_STAT, d); check("R1 status", d, 32'd0);
        rd(A_ENS, d);  check("R1 enable mask", d, 32'd0);
        rd(A_VEC, d);  check("R1 spurious reset", d, 32'd0);

        // R9 spurious vector
        spur_val = 32'hDEAD_BEEF;
        wr(A_SPUR, spur_val);
        rd(A_VEC, d);  check("R9 spurious vector", d, spur_val);
        rd(A_STAT, d); check("R9 spurious status", d, 32'd0);

        // R2 mode readback
        cfg(5, 2'd0, 3'd2, 32'h105);
        rd(5, d); check("R2 mode level high", d, 32'h02);
        cfg(6, 2'd1, 3'd5, 32'h106);
        rd(6, d); check("R2 mode rising", d, 32'h15);
        rd(38, d); check("R2 vector word", d, 32'h106);

        // R3 illegal triggers on an internal line
        wr(9, 32'h23); rd(9, d); check("R3 low on internal", d, 32'h00);
        wr(9, 32'h31); rd(9, d); check("R3 falling on internal", d, 32'h00);
        wr(0, 32'h24); rd(0, d); check("R3 low on line 0", d, 32'h24);
        wr(20, 32'h35); rd(20, d); check("R3 falling on external", d, 32'h35);
        wr(0, 32'h00); wr(20, 32'h00);

        // R4 / R6 / R7 / R8 level line
        wr(A_ENS, 32'h20);
        rd(A_ENS, d); check("R4 enable set", d, 32'h20);
        src[5] = 1'b1; idle(3);
        check("R6 level asserts", 32'(irq_n), 32'd0);
        rd(A_VEC, d);  check("R7 vector line 5", d, 32'h105);
        rd(A_STAT, d); check("R7 status line 5", d, 32'd5);
        check("R8 no self preempt", 32'(irq_n), 32'd1);
        wr(A_EOI, 32'h1234); idle(1);
        check("R10 eoi reopens level", 32'(irq_n), 32'd0);
        rd(A_STAT, d); check("R10 status after eoi", d, 32'd0);
        src[5] = 1'b0; idle(3);
        check("R6 level released", 32'(irq_n), 32'd1);

        // R5 / R11 rising edge
        wr(A_ENS, 32'h40);
        src[6] = 1'b1; idle(1); src[6] = 1'b0; idle(3);
        check("R5 edge latched", 32'(irq_n), 32'd0);
        rd(A_VEC, d); check("R11 edge vector", d, 32'h106);
        wr(A_EOI, 32'h0); idle(1);
        check("R11 ack cleared latch", 32'(irq_n), 32'd1);
        src[6] = 1'b1; idle(1); src[6] = 1'b0; idle(3);
        check("R5 second edge", 32'(irq_n), 32'd0);
        wr(A_PCLR, 32'h40); idle(1);
        check("R5 pending clear", 32'(irq_n), 32'd1);
        rd(A_VEC, d); check("R9 spurious after clear", d, spur_val);

        // R2 falling edge on external line 20
        src[20] = 1'b1;
        cfg(20, 2'd3, 3'd1, 32'h120);
        wr(A_ENS, 32'h0010_0000); idle(3);
        check("R2 falling idle high", 32'(irq_n), 32'd1);
        src[20] = 1'b0; idle(3);
        check("R2 falling edge", 32'(irq_n), 32'd0);
        rd(A_VEC, d); check("R2 falling vector", d, 32'h120);
        wr(A_EOI, 32'h0); idle(1);
        check("R11 falling latch cleared", 32'(irq_n), 32'd1);

        // R7 tie break and R8 preemption
        cfg(3, 2'd0, 3'd4, 32'h103);
        cfg(7, 2'd0, 3'd4, 32'h107);
        cfg(10, 2'd0, 3'd6, 32'h10A);
        wr(A_ENS, 32'h0000_0488);
        src[3] = 1'b1; src[7] = 1'b1; idle(3);
        rd(A_VEC, d); check("R7 tie lowest number", d, 32'h103);
        check("R8 equal does not preempt", 32'(irq_n), 32'd1);
        src[10] = 1'b1; idle(3);
        check("R8 higher preempts", 32'(irq_n), 32'd0);
        rd(A_VEC, d);  check("R7 preempt vector", d, 32'h10A);
        rd(A_STAT, d); check("R7 nested status", d, 32'd10);
        wr(A_EOI, 32'h0);
        rd(A_STAT, d); check("R10 pop to line 3", d, 32'd3);
        wr(A_EOI, 32'h0);
        rd(A_STAT, d); check("R10 pop to idle", d, 32'd0);
        src[3] = 1'b0; src[7] = 1'b0; src[10] = 1'b0;
        wr(A_ENC, 32'hFFFF_FFFF); idle(3);

        // R10 / R12 full nesting
        for (int k = 0; k < 8; k++) begin
            cfg(11 + k, 2'd0, 3'(k), 32'h200 + k);
            wr(A_ENS, 32'd1 << (11 + k));
            src[11 + k] = 1'b1; idle(3);
            rd(A_VEC, d); check("R12 nest fill", d, 32'h200 + k);
        end
        rd(A_STAT, d); check("R12 full status", d, 32'd18);
        check("R12 full blocks", 32'(irq_n), 32'd1);
        for (int k = 0; k < 8; k++) begin
            wr(A_EOI, 32'hFFFF_0000 | k);
            rd(A_STAT, d);
            check("R10 unwind status", d, (k == 7) ? 32'd0 : 32'(17 - k));
        end
        wr(A_EOI, 32'h0);
        rd(A_STAT, d); check("R10 extra eoi harmless", d, 32'd0);
        rd(A_VEC, d);  check("R10 idle after eight", d, 32'h207);
        wr(A_EOI, 32'h0);

        // R4 disable every line, including line 0 at low level
        cfg(0, 2'd2, 3'd0, 32'h100);
        wr(A_ENS, 32'h1); idle(3);
        check("R4 low level on line 0", 32'(irq_n), 32'd0);
        wr(A_ENC, 32'hFFFF_FFFF); idle(1);
        check("R4 all disabled", 32'(irq_n), 32'd1);
        rd(A_ENS, d); check("R4 mask cleared", d, 32'd0);
        src = '0; idle(3);

        // R7 / R8 random level mixes
        for (int it = 0; it < 40; it++) begin
            logic [31:0] ena, lv;
            int w;
            for (int i = 1; i < 16; i++)
                cfg(i, 2'd0, 3'($urandom_range(0, 7)), 32'h3000 + i);
            ena = ($urandom() & 32'h7FFF) << 1;
            lv  = ($urandom() & 32'h7FFF) << 1;
            wr(A_ENC, 32'hFFFF_FFFF);
            wr(A_ENS, ena);
            src = lv; idle(3);
            w = winner(ena & lv);
            if (w >= 0) begin
                check("R8 random request", 32'(irq_n), 32'd0);
                rd(A_VEC, d);  check("R7 random vector", d, 32'h3000 + w);
                rd(A_STAT, d); check("R7 random status", d, 32'(w));
                wr(A_EOI, 32'h0);
            end else begin
                check("R8 random quiet", 32'(irq_n), 32'd1);
                rd(A_VEC, d); check("R9 random spurious", d, spur_val);
            end
            src = '0; idle(3);
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule